// File: doc/BRIEF.md
# Keyed Configuration Port with GPIO Banks

This block puts a small configuration space behind a pair of byte-wide host ports: an index port that names a register and a data port that reads or writes it. The space is closed after reset. Host software opens it by writing a fixed key byte to the index port twice in succession, and closes it again with a different key byte. While it is open, a logical-device select register decides which register file the data port reaches. Identification registers give a device ID, a revision and a manufacturer code, and they cannot be written. The only register file implemented is the GPIO one.

The GPIO file holds a parameter-set number of 8-bit banks, each built from four consecutive registers: direction, output latch, synchronised pin state and per-pin output mode. The mode picks push-pull or open-drain drive. The block drives pad data and pad output enables, and it samples pad levels through a two-flop synchronizer. The port pair sits at one of two strapped base addresses.

The key sequencer is a three-state machine. The states are `KS_LOCKED`, `KS_HALF` and `KS_OPEN`. Its transitions:
- LOCKED to HALF on an index write of 0x87.
- HALF to OPEN on an index write of 0x87.
- HALF to LOCKED on an index write of any other value, or on any data-port write.
- OPEN to LOCKED on an index write of 0xAA.

In every other case the state holds.

Top module: `cfgp_keyed_gpio`

## Requirements
- R1: After reset the port is locked, the logical-device select reads 0, every direction, latch and mode bit is 0, and `pad_oe` and `pad_out` are all 0.
- R2: The index port is at host address 0x2E and the data port at 0x2F when `base_sel` is 0. They are at 0x4E and 0x4F when `base_sel` is 1. Writes to any other address leave the key state and all registers unchanged.
- R3: Two consecutive index writes of 0x87 open the port. If the first 0x87 is followed by an index write of another value, or by a data-port write, the port stays locked and the sequence restarts.
- R4: An index write of 0xAA while open locks the port again. After that, data-port reads return 0xFF.
- R5: While the port is locked, data-port writes change no register. Reads of the data port and of the index port return 0xFF.
- R6: Registers 0x20 and 0x21 return the device ID high and low bytes (default 0x0A55). Register 0x22 returns the revision (default 0x03). Registers 0x23 and 0x24 return 0x19 and 0x34. Writes to these registers are ignored. While open, an index-port read returns the current index.
- R7: Register 0x07 is the read/write logical-device select. The GPIO registers respond only when it holds 0x06. With any other value, their reads return 0 and writes to them are ignored.
- R8: Bank k has its base at 0xF0 − 0x10·k and drives pad bits [8k+7:8k]. The registers at base+0 to base+3 are: +0 direction (1 = output), +1 output latch, +2 pin state (read-only), +3 output mode (1 = push-pull, 0 = open-drain).
- R9: An output pin in push-pull mode has its output enable at 1 and drives its latch value.
- R10: An output pin in open-drain mode drives low (enable 1, data 0) when its latch is 0 and is released (enable 0) when its latch is 1. Input pins are never enabled, and `pad_out` is never 1 unless the pin is a push-pull output.
- R11: Bank k implements the pin count held in nibble k of `BANK_PINS` (default 8, 8, 6, 5). Unimplemented bits read 0 and are never driven. Registers that are not defined read 0.
- R12: The pin-state register samples pads through a two-flop synchronizer. A pad change set before clock edge N is returned by a data read strobed at edge N+2, but not by one strobed at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 1 | Base strap: 0 selects 0x2E/0x2F, 1 selects 0x4E/0x4F |
| io_addr | input | 8 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe; data appears on io_rdata after the edge |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered read data, held between reads |
| pad_in | input | 8·NUM_BANKS | Pad levels, asynchronous |
| pad_out | output | 8·NUM_BANKS | Pad drive data |
| pad_oe | output | 8·NUM_BANKS | Pad output enables |

## Verification
If the key sequencer is in the wrong state, the next data-port read shows it: 0xFF where register contents were expected, or the reverse. A wrongly stored latch, direction or mode bit reaches `pad_oe`/`pad_out` on the clock after the write, so a pad check straight after each configuration write catches it within one cycle. Decode mistakes in the bank address, the logical-device gate or the pin mask show up as a non-zero read of an undefined register or an unimplemented bit. A synchronizer of the wrong depth moves the first read that returns a new pad level one edge away from N+2.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } keyst_t;

    localparam logic [7:0] KEY_OPEN    = 8'h87;
    localparam logic [7:0] KEY_CLOSE   = 8'hAA;
    localparam logic [7:0] REG_LDSEL   = 8'h07;
    localparam logic [7:0] REG_DEVID_H = 8'h20;
    localparam logic [7:0] REG_DEVID_L = 8'h21;
    localparam logic [7:0] REG_REV     = 8'h22;
    localparam logic [7:0] REG_MFR_H   = 8'h23;
    localparam logic [7:0] REG_MFR_L   = 8'h24;
    localparam logic [7:0] LD_GPIO     = 8'h06;
    localparam logic [15:0] MFR_CODE   = 16'h1934;
    localparam logic [7:0] PORT_BASE0  = 8'h2E;
    localparam logic [7:0] PORT_BASE1  = 8'h4E;

    typedef enum logic [1:0] {
        BR_DIR   = 2'd0,
        BR_LATCH = 2'd1,
        BR_PINS  = 2'd2,
        BR_MODE  = 2'd3
    } bank_reg_t;

endpackage

// File: rtl/cfgp_sync2.sv
module cfgp_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/cfgp_keyseq.sv
module cfgp_keyseq
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output keyst_t     state,
    output logic       unlocked
);
    keyst_t next_state;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= KS_LOCKED;
        else        state <= next_state;
    end

    // transitions
    always_comb begin
        next_state = state;
        unique case (state)
            KS_LOCKED: begin
                if (idx_wr && wdata == KEY_OPEN) next_state = KS_HALF;
            end
            KS_HALF: begin
                if (idx_wr) next_state = (wdata == KEY_OPEN) ? KS_OPEN : KS_LOCKED;
                else if (dat_wr) next_state = KS_LOCKED;
            end
            KS_OPEN: begin
                if (idx_wr && wdata == KEY_CLOSE) next_state = KS_LOCKED;
            end
            default: next_state = KS_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unlocked = 1'b0;
        unique case (state)
            KS_OPEN:   unlocked = 1'b1;
            KS_LOCKED,
            KS_HALF:   unlocked = 1'b0;
            default:   unlocked = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
    import cfgp_pkg::*;
#(
    parameter logic [15:0] DEV_ID  = 16'h0A55,
    parameter logic [7:0]  DEV_REV = 8'h03
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       unlocked,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic [7:0] cur_index,
    output logic [7:0] ldsel,
    output logic       gpio_sel,
    output logic       gpio_wr,
    output logic [7:0] glob_rdata
);
    logic idx_store;
    logic ldsel_store;

    // the closing key is consumed by the sequencer, not stored
    assign idx_store   = unlocked && idx_wr && (wdata != KEY_CLOSE);
    assign ldsel_store = unlocked && dat_wr && (cur_index == REG_LDSEL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_index <= '0;
            ldsel     <= '0;
        end else begin
            if (idx_store)   cur_index <= wdata;
            if (ldsel_store) ldsel     <= wdata;
        end
    end

    assign gpio_sel = (ldsel == LD_GPIO);
    assign gpio_wr  = unlocked && dat_wr && gpio_sel;

    always_comb begin
        unique case (cur_index)
            REG_LDSEL:   glob_rdata = ldsel;
            REG_DEVID_H: glob_rdata = DEV_ID[15:8];
            REG_DEVID_L: glob_rdata = DEV_ID[7:0];
            REG_REV:     glob_rdata = DEV_REV;
            REG_MFR_H:   glob_rdata = MFR_CODE[15:8];
            REG_MFR_L:   glob_rdata = MFR_CODE[7:0];
            default:     glob_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfgp_gpio_bank.sv
module cfgp_gpio_bank
    import cfgp_pkg::*;
#(
    parameter logic [7:0] BASE  = 8'hF0,
    parameter int         NPINS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       sel,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic [7:0] pins_sync,
    output logic [7:0] rdata,
    output logic [7:0] dir,
    output logic [7:0] latch,
    output logic [7:0] mode,
    output logic [7:0] pad_out,
    output logic [7:0] pad_oe
);
    localparam logic [8:0] ONEHOT = 9'd1 << NPINS;
    localparam logic [8:0] MASK9  = ONEHOT - 9'd1;
    localparam logic [7:0] MASK   = MASK9[7:0];

    logic      hit;
    bank_reg_t sub;

    assign hit = (addr[7:2] == BASE[7:2]);
    assign sub = bank_reg_t'(addr[1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir   <= '0;
            latch <= '0;
            mode  <= '0;
        end else if (wr_en && hit) begin
            unique case (sub)
                BR_DIR:   dir   <= wdata & MASK;
                BR_LATCH: latch <= wdata & MASK;
                BR_MODE:  mode  <= wdata & MASK;
                BR_PINS:  ;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (sel && hit) begin
            unique case (sub)
                BR_DIR:   rdata = dir;
                BR_LATCH: rdata = latch;
                BR_PINS:  rdata = pins_sync & MASK;
                BR_MODE:  rdata = mode;
                default:  rdata = 8'h00;
            endcase
        end
    end

    // push-pull drives the latch; open-drain pulls low or releases
    assign pad_oe  = dir & (mode | ~latch);
    assign pad_out = dir & mode & latch;
endmodule

// File: rtl/cfgp_keyed_gpio.sv
module cfgp_keyed_gpio
    import cfgp_pkg::*;
#(
    parameter int                      NUM_BANKS = 4,
    parameter logic [4*NUM_BANKS-1:0]  BANK_PINS = 16'h5688,
    parameter logic [15:0]             DEV_ID    = 16'h0A55,
    parameter logic [7:0]              DEV_REV   = 8'h03
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   base_sel,
    input  logic [7:0]             io_addr,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    input  logic [8*NUM_BANKS-1:0] pad_in,
    output logic [8*NUM_BANKS-1:0] pad_out,
    output logic [8*NUM_BANKS-1:0] pad_oe
);
    localparam int PADW = 8 * NUM_BANKS;

    logic [7:0] port_base;
    logic       idx_hit, dat_hit, idx_wr, dat_wr;
    keyst_t     ks_state;
    logic       unlocked;
    logic [7:0] cur_index, ldsel, glob_rdata, reg_rdata;
    logic       gpio_sel, gpio_wr;
    logic [PADW-1:0] pins_sync;
    logic [PADW-1:0] dir_all, latch_all, mode_all, impl_mask;
    logic [7:0]      bank_rd [NUM_BANKS];

    assign port_base = base_sel ? PORT_BASE1 : PORT_BASE0;
    assign idx_hit   = (io_addr == port_base);
    assign dat_hit   = (io_addr == port_base + 8'd1);
    assign idx_wr    = io_wr && idx_hit;
    assign dat_wr    = io_wr && dat_hit;

    cfgp_keyseq u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr),
        .wdata    (io_wdata),
        .state    (ks_state),
        .unlocked (unlocked)
    );

    cfgp_ctrl #(
        .DEV_ID  (DEV_ID),
        .DEV_REV (DEV_REV)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlocked   (unlocked),
        .idx_wr     (idx_wr),
        .dat_wr     (dat_wr),
        .wdata      (io_wdata),
        .cur_index  (cur_index),
        .ldsel      (ldsel),
        .gpio_sel   (gpio_sel),
        .gpio_wr    (gpio_wr),
        .glob_rdata (glob_rdata)
    );

    cfgp_sync2 #(.WIDTH(PADW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (pins_sync)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        localparam int         NP = int'(BANK_PINS[4*k +: 4]);
        localparam logic [7:0] BB = 8'(8'hF0 - 8'h10 * k);
        localparam logic [8:0] M9 = (9'd1 << NP) - 9'd1;

        cfgp_gpio_bank #(
            .BASE  (BB),
            .NPINS (NP)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (gpio_wr),
            .sel       (gpio_sel),
            .addr      (cur_index),
            .wdata     (io_wdata),
            .pins_sync (pins_sync[8*k +: 8]),
            .rdata     (bank_rd[k]),
            .dir       (dir_all[8*k +: 8]),
            .latch     (latch_all[8*k +: 8]),
            .mode      (mode_all[8*k +: 8]),
            .pad_out   (pad_out[8*k +: 8]),
            .pad_oe    (pad_oe[8*k +: 8])
        );
        assign impl_mask[8*k +: 8] = M9[7:0];
    end

    always_comb begin
        reg_rdata = glob_rdata;
        for (int k = 0; k < NUM_BANKS; k++) reg_rdata = reg_rdata | bank_rd[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rdata <= 8'hFF;
        end else if (io_rd) begin
            if (!unlocked)    io_rdata <= 8'hFF;
            else if (idx_hit) io_rdata <= cur_index;
            else if (dat_hit) io_rdata <= reg_rdata;
            else              io_rdata <= 8'hFF;
        end
    end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   io_wr,
    input logic                   io_rd,
    input logic [7:0]             io_wdata,
    input logic [7:0]             io_rdata,
    input logic                   idx_hit,
    input logic                   dat_hit,
    input keyst_t                 ks_state,
    input logic [8*NUM_BANKS-1:0] dir_all,
    input logic [8*NUM_BANKS-1:0] latch_all,
    input logic [8*NUM_BANKS-1:0] mode_all,
    input logic [8*NUM_BANKS-1:0] impl_mask,
    input logic [8*NUM_BANKS-1:0] pad_out,
    input logic [8*NUM_BANKS-1:0] pad_oe
);
    AST_FOREIGN_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !idx_hit && !dat_hit) |=> ($stable(ks_state) && $stable(dir_all) && $stable(latch_all) && $stable(mode_all))); // R2
    AST_SECOND_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_state == KS_HALF && io_wr && idx_hit && io_wdata == KEY_OPEN) |=> (ks_state == KS_OPEN)); // R3
    AST_NO_SINGLE_KEY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_state == KS_LOCKED) |=> (ks_state != KS_OPEN)); // R3
    AST_CLOSE_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_state == KS_OPEN && io_wr && idx_hit && io_wdata == KEY_CLOSE) |=> (ks_state == KS_LOCKED)); // R4
    AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_state != KS_OPEN && io_wr) |=> ($stable(dir_all) && $stable(latch_all) && $stable(mode_all))); // R5
    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_state != KS_OPEN && io_rd) |=> (io_rdata == 8'hFF)); // R5
    AST_PP_DRIVES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & dir_all & mode_all) == (dir_all & mode_all)) && ((pad_out & dir_all & mode_all) == (latch_all & dir_all & mode_all))); // R9
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~(dir_all & mode_all)) == '0); // R10
    AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_all) == '0); // R10
    AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | dir_all | latch_all | mode_all) & ~impl_mask) == '0); // R11
endmodule

bind cfgp_keyed_gpio cfgp_checker #(.NUM_BANKS(NUM_BANKS)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .idx_hit   (idx_hit),
    .dat_hit   (dat_hit),
    .ks_state  (ks_state),
    .dir_all   (dir_all),
    .latch_all (latch_all),
    .mode_all  (mode_all),
    .impl_mask (impl_mask),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/cfgp_keyed_gpio_tb.sv
module cfgp_keyed_gpio_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_sel = 1'b0;
    logic [7:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;

    int checks = 0;
    int failures = 0;
    logic [7:0] ip = 8'h2E;
    logic [7:0] rv;

    always #5 clk = ~clk;

    cfgp_keyed_gpio dut_i (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic cfg_write(input logic [7:0] r, input logic [7:0] d);
        io_write(ip, r);
        io_write(ip + 8'd1, d);
    endtask

    task automatic cfg_read(input logic [7:0] r, output logic [7:0] d);
        io_write(ip, r);
        io_read(ip + 8'd1, d);
    endtask

    task automatic do_unlock();
        io_write(ip, 8'h87);
        io_write(ip, 8'h87);
    endtask

    task automatic t_reset();
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        check("R1 pad_out after reset", pad_out, 32'h0);
        io_read(ip + 8'd1, rv);
        check("R1 locked after reset", {24'h0, rv}, 32'hFF);
        do_unlock();
        cfg_read(8'h07, rv);
        check("R1 ldsel after reset", {24'h0, rv}, 32'h00);
        cfg_write(8'h07, 8'h06);
        cfg_read(8'hF3, rv);
        check("R1 bank0 mode after reset", {24'h0, rv}, 32'h00);
        cfg_read(8'hE1, rv);
        check("R1 bank1 latch after reset", {24'h0, rv}, 32'h00);
        io_write(ip, 8'hAA);
    endtask

    task automatic t_locked();
        io_write(ip, 8'hF0);
        io_write(ip + 8'd1, 8'hFF);
        check("R5 locked write leaves pads", pad_oe, 32'h0);
        io_read(ip, rv);
        check("R5 locked index read", {24'h0, rv}, 32'hFF);
        do_unlock();
        cfg_read(8'hF0, rv);
        check("R5 locked write did not store", {24'h0, rv}, 32'h00);
        io_write(ip, 8'hAA);
    endtask

    task automatic t_keyseq();
        io_write(ip, 8'h87); io_write(ip, 8'h55); io_write(ip, 8'h87);
        io_read(ip + 8'd1, rv);
        check("R3 broken key by index", {24'h0, rv}, 32'hFF);
        io_write(ip, 8'h55);
        io_write(ip, 8'h87); io_write(ip + 8'd1, 8'h00); io_write(ip, 8'h87);
        io_read(ip + 8'd1, rv);
        check("R3 broken key by data write", {24'h0, rv}, 32'hFF);
        io_write(ip, 8'h55);
        do_unlock();
        cfg_read(8'h20, rv);
        check("R3 two keys open", {24'h0, rv}, 32'h0A);
    endtask

    task automatic t_ids();
        cfg_read(8'h21, rv); check("R6 devid low", {24'h0, rv}, 32'h55);
        cfg_read(8'h22, rv); check("R6 revision", {24'h0, rv}, 32'h03);
        cfg_read(8'h23, rv); check("R6 mfr high", {24'h0, rv}, 32'h19);
        cfg_read(8'h24, rv); check("R6 mfr low", {24'h0, rv}, 32'h34);
        cfg_write(8'h20, 8'h77);
        cfg_read(8'h20, rv); check("R6 id write ignored", {24'h0, rv}, 32'h0A);
        io_read(ip, rv); check("R6 index readback", {24'h0, rv}, 32'h20);
    endtask

    task automatic t_ldsel();
        cfg_write(8'h07, 8'h03);
        cfg_read(8'h07, rv); check("R7 ldsel readback", {24'h0, rv}, 32'h03);
        cfg_write(8'hF0, 8'hFF);
        cfg_read(8'hF0, rv); check("R7 gpio read gated", {24'h0, rv}, 32'h00);
        check("R7 gpio write gated", pad_oe, 32'h0);
        cfg_write(8'h07, 8'h06);
        cfg_read(8'hF0, rv); check("R7 gpio write did not store", {24'h0, rv}, 32'h00);
    endtask

    task automatic t_pushpull();
        cfg_write(8'hF3, 8'hFF);
        cfg_write(8'hF1, 8'hA5);
        cfg_write(8'hF0, 8'hFF);
        check("R9 pp oe", pad_oe[7:0], 32'hFF);
        check("R9 pp out", pad_out[7:0], 32'hA5);
        cfg_read(8'hF1, rv); check("R8 latch readback", {24'h0, rv}, 32'hA5);
        cfg_read(8'hF3, rv); check("R8 mode readback", {24'h0, rv}, 32'hFF);
    endtask

    task automatic t_opendrain();
        cfg_write(8'hE1, 8'h33);
        cfg_write(8'hE0, 8'h0F);
        check("R10 od oe", pad_oe[15:8], 32'h0C);
        check("R10 od out", pad_out[15:8], 32'h00);
        cfg_write(8'hE3, 8'h01);
        check("R10 mixed mode oe", pad_oe[15:8], 32'h0D);
        check("R10 mixed mode out", pad_out[15:8], 32'h01);
        cfg_read(8'hE0, rv); check("R8 dir readback", {24'h0, rv}, 32'h0F);
    endtask

    task automatic t_unimpl();
        cfg_write(8'hD3, 8'hFF);
        cfg_write(8'hD1, 8'hFF);
        cfg_write(8'hD0, 8'hFF);
        cfg_read(8'hD0, rv); check("R11 bank2 dir masked", {24'h0, rv}, 32'h3F);
        check("R11 bank2 pads masked", pad_oe[23:16], 32'h3F);
        cfg_write(8'hC0, 8'hFF);
        check("R11 bank3 pads masked", pad_oe[31:24], 32'h1F);
        cfg_write(8'hC0, 8'h00);
        cfg_read(8'h30, rv); check("R11 undefined reg", {24'h0, rv}, 32'h00);
        cfg_read(8'hB0, rv); check("R11 no fifth bank", {24'h0, rv}, 32'h00);
    endtask

    task automatic t_sync();
        io_write(ip, 8'hC2);
        pad_in[31:24] = 8'hF3;
        @(posedge clk); @(negedge clk);
        io_read(ip + 8'd1, rv);
        check("R12 edge N+1 old value", {24'h0, rv}, 32'h00);
        io_read(ip + 8'd1, rv);
        check("R12 later read masked", {24'h0, rv}, 32'h13);
        pad_in[31:24] = 8'h0A;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        io_read(ip + 8'd1, rv);
        check("R12 edge N+2 new value", {24'h0, rv}, 32'h0A);
    endtask

    task automatic t_lock();
        io_write(ip, 8'hAA);
        io_read(ip + 8'd1, rv);
        check("R4 lock key closes", {24'h0, rv}, 32'hFF);
    endtask

    task automatic t_base();
        base_sel = 1'b1;
        io_write(8'h2E, 8'h87); io_write(8'h2E, 8'h87);
        io_read(8'h4F, rv);
        check("R2 old base ignored", {24'h0, rv}, 32'hFF);
        ip = 8'h4E;
        do_unlock();
        cfg_read(8'h24, rv);
        check("R2 alternate base", {24'h0, rv}, 32'h34);
        io_write(8'h2F, 8'h00);
        cfg_read(8'hF0, rv);
        check("R2 foreign write ignored", {24'h0, rv}, 32'hFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_keyseq();
        t_ids();
        t_ldsel();
        t_pushpull();
        t_opendrain();
        t_unimpl();
        t_sync();
        t_lock();
        t_base();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule